// File: doc/BRIEF.md
# Self-Timed Non-Volatile Byte Write Controller

This block models the two non-volatile arrays of a small controller and the timed sequencer that writes them. The program array holds `PROG_WORDS` 16-bit words, reached one byte at a time through a byte address. The data array holds `EE_BYTES` bytes. A programming front end hands the block one request per cycle: a byte read, a byte write, or a chip erase. Each write or erase then runs for a fixed number of system-clock cycles, set by parameters, and `busy` stays high for that whole time.

The two arrays behave differently on a write. A program-array write can only clear bits: the stored byte becomes the old byte AND the new data, so a byte must be chip-erased before it can be raised again. A data-array write runs a self-timed clear of the byte to FF and then a write phase, so the old contents do not matter. While a write is running, a read of the byte being written returns FF. The host can therefore poll by reading the byte back until the written value appears. During a chip erase, every read returns FF.

Requests are decoded from `req_op`. The state machine has five states:
- ST_IDLE
- ST_PGM_WR: program-array write
- ST_EE_CLR: data-array byte clear
- ST_EE_WR: data-array byte write
- ST_CHIP_CLR: chip erase

Its transitions:
- IDLE to PGM_WR: write with `req_ee`=0.
- IDLE to EE_CLR: write with `req_ee`=1.
- IDLE to CHIP_CLR: erase request.
- EE_CLR to EE_WR: on the last clear cycle.
- PGM_WR, EE_WR and CHIP_CLR back to IDLE: on their last cycle. The array update is committed on that same clock edge.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `wr_err` are 0. Every location in both arrays reads FF.
- R2: The `req_op` encoding is 0 = read, 1 = write, 2 = chip erase, 3 = no operation. A read sampled at a clock edge gives `rd_valid`=1 in the next cycle, with the byte from the array chosen by `req_ee` (0 = program, 1 = data). The two arrays are separate address spaces. For the data array only the low log2(`EE_BYTES`) address bits are used.
- R3: A program-array write accepted while idle raises `busy` in the next cycle, for exactly `T_PGM` cycles. The stored byte then becomes old AND data.
- R4: A data-array write accepted while idle keeps `busy` high for exactly `T_EE_CLR`+`T_EE_WR` cycles. The stored byte then equals the data, whatever the old value was.
- R5: A read of the byte under write, in the same array, sampled in any cycle where `busy`=1 returns FF. This includes the last busy cycle. A read sampled in the first cycle after `busy` falls returns the written result.
- R6: During a write, reads of any other location return the stored contents.
- R7: A chip erase keeps `busy` high for exactly `T_ERASE` cycles. Every read sampled during that time returns FF. Afterwards every location of both arrays reads FF.
- R8: A write or erase request sampled while `busy`=1 is dropped and has no effect on either array. It sets `wr_err`, which stays 1 until reset.
- R9: `req_op`=3 is ignored. It produces no `rd_valid`, no `busy` and no `wr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 chip erase, 3 none |
| req_ee | input | 1 | Array select: 0 program, 1 data |
| req_addr | input | log2(2*PROG_WORDS) | Byte address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Timed operation running |
| rd_valid | output | 1 | Read data valid this cycle |
| rd_data | output | 8 | Read data |
| wr_err | output | 1 | Sticky flag: request dropped while busy |

## Verification
Two functions can meet in one cycle: a polling read of the byte under write, and the commit of that write. On the commit edge the read must still return FF, and it must not pick up the new array contents. The bench provokes this by issuing a read of the target byte in every cycle that `busy` is seen high, up to and including the last one. Each of those reads must return FF, and the read issued just after `busy` drops must return the committed value. A dropped request arriving during a running write is judged the same way: `wr_err` is checked, and the location that request named is read back afterwards to confirm it is unchanged.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } nvm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PGM_WR   = 3'd1,
        ST_EE_CLR   = 3'd2,
        ST_EE_WR    = 3'd3,
        ST_CHIP_CLR = 3'd4
    } nvm_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/nvm_ctrl_timer.sv
module nvm_ctrl_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));

    AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0)); // R3

endmodule

// File: rtl/nvm_ctrl_bank.sv
module nvm_ctrl_bank #(
    parameter int DEPTH    = 64,
    parameter bit AND_MODE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [7:0]               wr_data,
    input  logic                     erase_all,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [7:0]               rd_data
);
    import nvm_ctrl_pkg::*;

    logic [7:0] mem [DEPTH];
    logic [7:0] old_byte;
    logic [7:0] new_byte;

    assign old_byte = mem[wr_addr];

    generate
        if (AND_MODE) begin : g_clear_only
            assign new_byte = old_byte & wr_data;

            AST_PGM_BITS_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !erase_all) |=> ((mem[$past(wr_addr)] & ~$past(old_byte)) == 8'h00)); // R3
        end else begin : g_replace
            assign new_byte = wr_data;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (erase_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (wr_en) begin
            mem[wr_addr] <= new_byte;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl #(
    parameter int PROG_WORDS = 512,
    parameter int EE_BYTES   = 64,
    parameter int T_PGM      = 24,
    parameter int T_EE_CLR   = 16,
    parameter int T_EE_WR    = 20,
    parameter int T_ERASE    = 48
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [1:0]                        req_op,
    input  logic                              req_ee,
    input  logic [$clog2(2*PROG_WORDS)-1:0]   req_addr,
    input  logic [7:0]                        req_wdata,
    output logic                              busy,
    output logic                              rd_valid,
    output logic [7:0]                        rd_data,
    output logic                              wr_err
);
    import nvm_ctrl_pkg::*;

    localparam int PBYTES = 2 * PROG_WORDS;
    localparam int PAW    = $clog2(PBYTES);
    localparam int EAW    = $clog2(EE_BYTES);
    localparam int TMAX1  = (T_PGM > T_EE_CLR) ? T_PGM : T_EE_CLR;
    localparam int TMAX2  = (T_EE_WR > T_ERASE) ? T_EE_WR : T_ERASE;
    localparam int TMAX   = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
    localparam int TW     = $clog2(TMAX + 1);

    nvm_state_e state, state_nx;
    nvm_op_e    op;
    logic           tgt_ee;
    logic [PAW-1:0] tgt_addr;
    logic [7:0]     tgt_data;

    logic           t_load;
    logic [TW-1:0]  t_val;
    logic           t_last;

    logic           pgm_we, ee_we, erase_all;
    logic [7:0]     ee_wdata;
    logic [7:0]     pgm_rd, ee_rd;
    logic           rd_req, mod_req, addr_hit, poll_ff;
    logic [7:0]     rd_next;

    assign op      = nvm_op_e'(req_op);
    assign rd_req  = req_valid && (op == OP_READ);
    assign mod_req = req_valid && (op == OP_WRITE || op == OP_ERASE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Captured request of the running operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_ee   <= 1'b0;
            tgt_addr <= '0;
            tgt_data <= 8'h00;
        end else if (state == ST_IDLE && req_valid && op == OP_WRITE) begin
            tgt_ee   <= req_ee;
            tgt_addr <= req_addr;
            tgt_data <= req_wdata;
        end
    end

    // Next state and timer control
    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid && op == OP_WRITE) begin
                    state_nx = req_ee ? ST_EE_CLR : ST_PGM_WR;
                    t_load   = 1'b1;
                    t_val    = req_ee ? TW'(T_EE_CLR) : TW'(T_PGM);
                end else if (req_valid && op == OP_ERASE) begin
                    state_nx = ST_CHIP_CLR;
                    t_load   = 1'b1;
                    t_val    = TW'(T_ERASE);
                end
            end
            ST_PGM_WR:   if (t_last) state_nx = ST_IDLE;
            ST_EE_CLR: begin
                if (t_last) begin
                    state_nx = ST_EE_WR;
                    t_load   = 1'b1;
                    t_val    = TW'(T_EE_WR);
                end
            end
            ST_EE_WR:    if (t_last) state_nx = ST_IDLE;
            ST_CHIP_CLR: if (t_last) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Outputs and array strobes
    always_comb begin
        busy      = (state != ST_IDLE);
        pgm_we    = (state == ST_PGM_WR) && t_last;
        ee_we     = (state == ST_EE_CLR || state == ST_EE_WR) && t_last;
        ee_wdata  = (state == ST_EE_CLR) ? ERASED_BYTE : tgt_data;
        erase_all = (state == ST_CHIP_CLR) && t_last;
        addr_hit  = req_ee ? (req_addr[EAW-1:0] == tgt_addr[EAW-1:0])
                           : (req_addr == tgt_addr);
        poll_ff   = (state == ST_CHIP_CLR) ||
                    (busy && (tgt_ee == req_ee) && addr_hit);
        rd_next   = poll_ff ? ERASED_BYTE : (req_ee ? ee_rd : pgm_rd);
    end

    nvm_ctrl_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    nvm_ctrl_bank #(.DEPTH(PBYTES), .AND_MODE(1'b1)) u_pgm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (pgm_we),
        .wr_addr   (tgt_addr),
        .wr_data   (tgt_data),
        .erase_all (erase_all),
        .rd_addr   (req_addr),
        .rd_data   (pgm_rd)
    );

    nvm_ctrl_bank #(.DEPTH(EE_BYTES), .AND_MODE(1'b0)) u_ee (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ee_we),
        .wr_addr   (tgt_addr[EAW-1:0]),
        .wr_data   (ee_wdata),
        .erase_all (erase_all),
        .rd_addr   (req_addr[EAW-1:0]),
        .rd_data   (ee_rd)
    );

    // Read return and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
            wr_err   <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= rd_next;
            if (mod_req && busy) wr_err <= 1'b1;
        end
    end

    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid); // R2
    AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_WRITE && !busy) |=> busy); // R3
    AST_ERASE_POLLS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && state == ST_CHIP_CLR) |=> (rd_data == ERASED_BYTE)); // R7
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && busy) |=> wr_err); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err); // R8
    AST_NOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_NONE && !busy) |=> (!busy && !rd_valid)); // R9

endmodule

// File: tb/nvm_ctrl_tb_top.sv
module nvm_ctrl_tb_top;

    localparam int T_PGM    = 24;
    localparam int T_EE_CLR = 16;
    localparam int T_EE_WR  = 20;
    localparam int T_ERASE  = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd3;
    logic       req_ee = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, rd_valid, wr_err;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] pgm_m [1024];
    logic [7:0] ee_m  [64];

    always #10 clk = ~clk;

    nvm_ctrl #(.T_PGM(T_PGM), .T_EE_CLR(T_EE_CLR), .T_EE_WR(T_EE_WR), .T_ERASE(T_ERASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_ee(req_ee),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .wr_err(wr_err));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard entries as read data returns
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 stray rd_valid", 1, 0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Driver: called at a negedge, returns at the next negedge
    task automatic drive(input logic [1:0] op, input logic ee, input logic [9:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_op = op; req_ee = ee; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd3;
    endtask

    task automatic rd(input logic ee, input logic [9:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        drive(2'd0, ee, a, 8'h00);
    endtask

    function automatic logic [7:0] model(input logic ee, input logic [9:0] a);
        return ee ? ee_m[a[5:0]] : pgm_m[a];
    endfunction

    // Write, poll the target in every busy cycle, then check length and result
    task automatic wr_poll(input logic ee, input logic [9:0] a, input logic [7:0] d,
                           input int exp_len, input string tag);
        int n = 0;
        drive(2'd1, ee, a, d);
        while (busy) begin
            n++;
            rd(ee, a, 8'hFF, {tag, " R5 poll FF"});
        end
        if (ee) ee_m[a[5:0]] = d; else pgm_m[a] = pgm_m[a] & d;
        check({tag, " busy length"}, n, exp_len);
        rd(ee, a, model(ee, a), {tag, " R5 result after busy"});
    endtask

    initial begin
        int n;
        for (int i = 0; i < 1024; i++) pgm_m[i] = 8'hFF;
        for (int i = 0; i < 64; i++) ee_m[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 wr_err", wr_err, 0);
        rd(1'b0, 10'h000, 8'hFF, "R1 pgm low erased");
        rd(1'b0, 10'h3FF, 8'hFF, "R1 pgm top erased");
        rd(1'b1, 10'h03F, 8'hFF, "R1 ee top erased");

        // R3 program write, bits cleared only
        wr_poll(1'b0, 10'h010, 8'hA5, T_PGM, "R3 pgm 010");
        wr_poll(1'b0, 10'h155, 8'h3C, T_PGM, "R3 pgm 155");
        wr_poll(1'b0, 10'h155, 8'hF0, T_PGM, "R3 pgm AND");
        rd(1'b0, 10'h155, 8'h30, "R3 AND result 30");

        // R6 other address during a write, R8 dropped write
        drive(2'd1, 1'b0, 10'h200, 8'h0F);
        rd(1'b0, 10'h010, 8'hA5, "R6 other pgm during write");
        rd(1'b1, 10'h010, 8'hFF, "R2 ee space separate during write");
        drive(2'd1, 1'b1, 10'h007, 8'h00);
        @(negedge clk);
        check("R8 wr_err after drop", wr_err, 1);
        while (busy) @(negedge clk);
        pgm_m[10'h200] = 8'h0F;
        rd(1'b1, 10'h007, 8'hFF, "R8 dropped ee write had no effect");
        rd(1'b0, 10'h200, 8'h0F, "R3 pgm 200 committed");

        // R4 data array replaces outright
        wr_poll(1'b1, 10'h005, 8'h81, T_EE_CLR + T_EE_WR, "R4 ee 05");
        wr_poll(1'b1, 10'h005, 8'h42, T_EE_CLR + T_EE_WR, "R4 ee rewrite");
        rd(1'b1, 10'h3C5, 8'h42, "R2 ee uses low address bits");
        rd(1'b0, 10'h005, 8'hFF, "R2 pgm 005 untouched by ee");

        // R8 erase dropped during ee write
        drive(2'd1, 1'b1, 10'h020, 8'h99);
        drive(2'd2, 1'b0, 10'h000, 8'h00);
        while (busy) @(negedge clk);
        ee_m[6'h20] = 8'h99;
        rd(1'b0, 10'h010, 8'hA5, "R8 dropped erase kept pgm");
        rd(1'b1, 10'h020, 8'h99, "R4 ee 20 written");
        check("R8 wr_err sticky", wr_err, 1);

        // R9 no-op
        drive(2'd3, 1'b0, 10'h010, 8'h00);
        check("R9 no busy", busy, 0);
        @(negedge clk);
        check("R9 no rd_valid", rd_valid, 0);

        // R7 chip erase
        drive(2'd2, 1'b0, 10'h000, 8'h00);
        n = 0;
        while (busy) begin
            n++;
            rd(n[0], 10'h010, 8'hFF, "R7 read during erase");
        end
        check("R7 erase length", n, T_ERASE);
        rd(1'b0, 10'h010, 8'hFF, "R7 pgm 010 erased");
        rd(1'b0, 10'h155, 8'hFF, "R7 pgm 155 erased");
        rd(1'b1, 10'h005, 8'hFF, "R7 ee 05 erased");
        rd(1'b1, 10'h020, 8'hFF, "R7 ee 20 erased");
        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule